// File: doc/BRIEF.md
# Per-Pin Pad Configuration Controller

This block keeps a small configuration register for every I/O line of one port group and turns those registers into the control signals of each pad. Software reaches the registers over a byte-wide register bus. The bus has an address, a write strobe, write data and combinational read data. A write-protect input locks the configuration against writes but still allows reads.

For each pin, an ownership bit selects who drives the pad. When the bit is clear, the port's own direction and output registers drive it. When the bit is set, an alternate peripheral's direction and output signals drive it instead. Input sampling is controlled separately from ownership. A pin with its input buffer enabled is synchronized and captured into the input-value register even while a peripheral owns the pin. A pin with its input buffer disabled reads back as zero. The register also supplies the pull-enable, open-drain and two-bit slew-limit controls for the pad.

Top module: `pin_cfg_ctrl`

## Requirements
- R1: After reset, every configuration register reads 0x00. The port registers own every pad and every input-value bit is 0.
- R2: The register for pin n answers at bus address 0x40 + n. Field positions are: bit 0 owner select (1 = peripheral), bit 1 input enable, bit 2 pull enable, bit 3 open-drain enable, bits 5:4 slew code. Bits 7:6 always read 0. Any address outside 0x40..0x40+NPINS-1 reads 0x00 and a write to it changes nothing.
- R3: While `wr_protect` is 1, a bus write leaves every register unchanged. Reads still return the stored values.
- R4: With the owner select at 0, the pad's direction follows `port_dir[n]` and its output value follows `port_out[n]`. `alt_dir` and `alt_out` have no effect on that pin.
- R5: With the owner select at 1, the pad's direction follows `alt_dir[n]` and its output value follows `alt_out[n]`. `port_dir` and `port_out` have no effect on that pin.
- R6: With open drain enabled, `pad_do[n]` is 0 and `pad_oe[n]` is 1 only when the selected direction is output and the selected value is 0. With open drain disabled, `pad_oe[n]` equals the selected direction and `pad_do[n]` equals the selected value.
- R7: `pad_pull_en[n]` is 1 only when the pull bit is set and the selected direction is input (0).
- R8: `pad_ie[n]` equals the input-enable bit. While input enable is 1, `in_value[n]` shows `pad_in[n]` as it was three clock edges earlier, whoever owns the pin. While input enable is 0, `in_value[n]` is 0.
- R9: `pad_slew[2n+1:2n]` carries pin n's slew code unchanged: 0 = no limit, 1 = 4x, 2 = 8x, 3 = 12x slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| wr_protect | input | 1 | Blocks configuration writes when 1 |
| port_dir | input | NPINS | Port direction register (1 = output) |
| port_out | input | NPINS | Port output value register |
| alt_dir | input | NPINS | Peripheral direction per pin |
| alt_out | input | NPINS | Peripheral output value per pin |
| pad_in | input | NPINS | Raw pad level, asynchronous |
| pad_oe | output | NPINS | Pad driver enable |
| pad_do | output | NPINS | Pad driven value |
| pad_pull_en | output | NPINS | Pad pull resistor enable |
| pad_ie | output | NPINS | Pad input buffer enable |
| pad_slew | output | 2*NPINS | Slew code, two bits per pin |
| in_value | output | NPINS | Synchronized, gated input-value register |

## Verification
Random register contents are combined with independent random values on `port_*`, `alt_*` and `pad_in`. Because the two sources usually differ, every pad output shows which source owns the pin and whether open drain has suppressed the high level. Directed cases cover the edges of the address window, the unimplemented top bits, writes made under protection, and the three-edge input latency. The latency check is distinguished from a two-edge or four-edge path by sampling on both sides of the update. Input capture is also checked with the input buffer enabled on a peripheral-owned pin and disabled on a port-owned output pin.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;

  localparam int CFG_W = 6;

  // Packed order matches the bus bit layout: [5:4] slew, [3] odrain,
  // [2] pull, [1] inen, [0] owner select.
  typedef struct packed {
    logic [1:0] slew;
    logic       odrain;
    logic       pull;
    logic       inen;
    logic       muxen;
  } pin_cfg_t;

endpackage

// File: rtl/pincfg_regfile.sv
module pincfg_regfile
  import pincfg_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [7:0]              bus_wdata,
  input  logic                    wr_protect,
  output logic [7:0]              bus_rdata,
  output logic [NPINS*CFG_W-1:0]  cfg_flat
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] NPINS_A = ADDR_W'(NPINS);

  logic [ADDR_W-1:0] offs;
  logic              hit;
  logic              wr_ok;
  logic              unused_wdata_hi;
  pin_cfg_t          cfg_q [NPINS];
  pin_cfg_t          cfg_d [NPINS];

  assign offs            = bus_addr - BASE_A;
  assign hit             = (bus_addr >= BASE_A) && (offs < NPINS_A);
  assign wr_ok           = bus_we && hit && !wr_protect;
  assign unused_wdata_hi = ^bus_wdata[7:6];

  for (genvar i = 0; i < NPINS; i++) begin : g_reg
    logic sel;
    assign sel = wr_ok && (offs == ADDR_W'(i));

    always_comb begin
      cfg_d[i] = cfg_q[i];
      if (sel) cfg_d[i] = pin_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else        cfg_q[i] <= cfg_d[i];
    end

    assign cfg_flat[i*CFG_W +: CFG_W] = cfg_q[i];
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (hit) bus_rdata = {2'b00, cfg_q[offs[IDX_W-1:0]]};
  end

endmodule

// File: rtl/pincfg_pad_ctrl.sv
module pincfg_pad_ctrl
  import pincfg_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS*CFG_W-1:0] cfg_flat,
  input  logic [NPINS-1:0]       port_dir,
  input  logic [NPINS-1:0]       port_out,
  input  logic [NPINS-1:0]       alt_dir,
  input  logic [NPINS-1:0]       alt_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pad_do,
  output logic [NPINS-1:0]       pad_pull_en,
  output logic [NPINS-1:0]       pad_ie,
  output logic [2*NPINS-1:0]     pad_slew
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_cfg_t cfg;
    logic     sel_dir;
    logic     sel_out;

    assign cfg     = pin_cfg_t'(cfg_flat[i*CFG_W +: CFG_W]);
    assign sel_dir = cfg.muxen ? alt_dir[i] : port_dir[i];
    assign sel_out = cfg.muxen ? alt_out[i] : port_out[i];

    // Open drain: a high level releases the driver, only low is driven.
    assign pad_oe[i]         = sel_dir & ~(cfg.odrain & sel_out);
    assign pad_do[i]         = sel_out & ~cfg.odrain;
    assign pad_pull_en[i]    = cfg.pull & ~sel_dir;
    assign pad_ie[i]         = cfg.inen;
    assign pad_slew[2*i +: 2] = cfg.slew;
  end

endmodule

// File: rtl/pincfg_in_sync.sv
module pincfg_in_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] inen,
  output logic [NPINS-1:0] in_value
);

  logic [NPINS-1:0] s1_q;
  logic [NPINS-1:0] s2_q;
  logic [NPINS-1:0] val_d;
  logic [NPINS-1:0] val_q;

  always_comb begin
    val_d = s2_q & inen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      val_q <= '0;
    end else begin
      s1_q  <= pad_in;
      s2_q  <= s1_q;
      val_q <= val_d;
    end
  end

  assign in_value = val_q;

endmodule

// File: rtl/pin_cfg_ctrl.sv
module pin_cfg_ctrl
  import pincfg_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int BASE  = 'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         bus_addr,
  input  logic               bus_we,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               wr_protect,
  input  logic [NPINS-1:0]   port_dir,
  input  logic [NPINS-1:0]   port_out,
  input  logic [NPINS-1:0]   alt_dir,
  input  logic [NPINS-1:0]   alt_out,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_do,
  output logic [NPINS-1:0]   pad_pull_en,
  output logic [NPINS-1:0]   pad_ie,
  output logic [2*NPINS-1:0] pad_slew,
  output logic [NPINS-1:0]   in_value
);

  logic                   rst_meta_q;
  logic                   rst_core_n;
  logic [NPINS*CFG_W-1:0] cfg_flat;

  // Reset asserts asynchronously, deasserts on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  pincfg_regfile #(.NPINS(NPINS), .ADDR_W(8), .BASE(BASE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .wr_protect (wr_protect),
    .bus_rdata  (bus_rdata),
    .cfg_flat   (cfg_flat)
  );

  pincfg_pad_ctrl #(.NPINS(NPINS)) u_pads (
    .cfg_flat    (cfg_flat),
    .port_dir    (port_dir),
    .port_out    (port_out),
    .alt_dir     (alt_dir),
    .alt_out     (alt_out),
    .pad_oe      (pad_oe),
    .pad_do      (pad_do),
    .pad_pull_en (pad_pull_en),
    .pad_ie      (pad_ie),
    .pad_slew    (pad_slew)
  );

  pincfg_in_sync #(.NPINS(NPINS)) u_insync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pad_in   (pad_in),
    .inen     (pad_ie),
    .in_value (in_value)
  );

endmodule

// File: rtl/pin_cfg_chk.sv
module pin_cfg_chk
  import pincfg_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic                   wr_protect,
  input logic [7:0]             bus_rdata,
  input logic [NPINS*CFG_W-1:0] cfg_flat,
  input logic [NPINS-1:0]       port_out,
  input logic [NPINS-1:0]       pad_oe,
  input logic [NPINS-1:0]       pad_do,
  input logic [NPINS-1:0]       pad_pull_en,
  input logic [NPINS-1:0]       in_value
);

  logic [NPINS-1:0] muxen_v;
  logic [NPINS-1:0] inen_v;
  logic [NPINS-1:0] odrain_v;

  for (genvar i = 0; i < NPINS; i++) begin : g_split
    assign muxen_v[i]  = cfg_flat[i*CFG_W + 0];
    assign inen_v[i]   = cfg_flat[i*CFG_W + 1];
    assign odrain_v[i] = cfg_flat[i*CFG_W + 3];
  end

  AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:6] == 2'b00); // R2

  AST_WP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wr_protect) |=> (cfg_flat == $past(cfg_flat))); // R3

  AST_PORT_OWNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((~muxen_v & ~odrain_v & (pad_do ^ port_out)) == '0)); // R4

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((odrain_v & pad_do) == '0)); // R6

  AST_PULL_IN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_en & pad_oe) == '0)); // R7

  AST_INVAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((in_value & ~$past(inen_v)) == '0)); // R8

endmodule

bind pin_cfg_ctrl pin_cfg_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .wr_protect  (wr_protect),
  .bus_rdata   (bus_rdata),
  .cfg_flat    (cfg_flat),
  .port_out    (port_out),
  .pad_oe      (pad_oe),
  .pad_do      (pad_do),
  .pad_pull_en (pad_pull_en),
  .in_value    (in_value)
);

// File: tb/tb_pin_cfg_ctrl.sv
module tb_pin_cfg_ctrl;

  localparam int N = 32;
  localparam int BASE = 'h40;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     bus_addr;
  logic           bus_we;
  logic [7:0]     bus_wdata;
  logic [7:0]     bus_rdata;
  logic           wr_protect;
  logic [N-1:0]   port_dir, port_out, alt_dir, alt_out, pad_in;
  logic [N-1:0]   pad_oe, pad_do, pad_pull_en, pad_ie, in_value;
  logic [2*N-1:0] pad_slew;

  int n_tests = 0;
  int n_fail  = 0;
  logic [5:0] model [N];

  always #10 clk = ~clk;

  pin_cfg_ctrl #(.NPINS(N), .BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_protect(wr_protect),
    .port_dir(port_dir), .port_out(port_out), .alt_dir(alt_dir),
    .alt_out(alt_out), .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
    .pad_pull_en(pad_pull_en), .pad_ie(pad_ie), .pad_slew(pad_slew),
    .in_value(in_value)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] sel_dir_f();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = model[i][0] ? alt_dir[i] : port_dir[i];
    return r;
  endfunction

  function automatic logic [N-1:0] sel_out_f();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = model[i][0] ? alt_out[i] : port_out[i];
    return r;
  endfunction

  function automatic logic [N-1:0] fld_f(input int b);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = model[i][b];
    return r;
  endfunction

  function automatic logic [2*N-1:0] slew_f();
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = model[i][5:4];
    return r;
  endfunction

  function automatic logic [7:0] rd_f(input logic [7:0] a);
    if (a >= 8'(BASE) && a < 8'(BASE + N)) return {2'b00, model[a - 8'(BASE)]};
    return 8'h00;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic wp);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; wr_protect = wp;
    if (!wp && a >= 8'(BASE) && a < 8'(BASE + N)) model[a - 8'(BASE)] = d[5:0];
    @(negedge clk);
    bus_we = 1'b0; wr_protect = 1'b0;
  endtask

  task automatic bus_read_chk(input logic [7:0] a, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata == rd_f(a), req, 64'(bus_rdata), 64'(rd_f(a)));
  endtask

  // Combinational pad outputs against the model (call away from clock edges).
  task automatic pads_chk();
    logic [N-1:0] d, v, od;
    d = sel_dir_f(); v = sel_out_f(); od = fld_f(3);
    #1;
    chk(pad_oe == (d & ~(od & v)), "R4/R5/R6 pad_oe", 64'(pad_oe), 64'(d & ~(od & v)));
    chk(pad_do == (v & ~od), "R4/R5/R6 pad_do", 64'(pad_do), 64'(v & ~od));
    chk(pad_pull_en == (fld_f(2) & ~d), "R7 pull", 64'(pad_pull_en), 64'(fld_f(2) & ~d));
    chk(pad_ie == fld_f(1), "R8 pad_ie", 64'(pad_ie), 64'(fld_f(1)));
    chk(pad_slew == slew_f(), "R9 slew", pad_slew, slew_f());
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    for (int i = 0; i < N; i++) model[i] = '0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; wr_protect = 1'b0;
    port_dir = '0; port_out = '0; alt_dir = '0; alt_out = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    port_dir = 32'hF0F0_1234; port_out = 32'h0FF0_ABCD;
    alt_dir = 32'h1111_2222; alt_out = 32'h3333_4444; pad_in = 32'hFFFF_FFFF;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < N; i++) bus_read_chk(8'(BASE + i), "R1 reset read");
    chk(in_value == '0, "R1 in_value", 64'(in_value), 0);
    pads_chk();

    // R2 field layout, upper bits dropped, window edges
    bus_write(8'(BASE + 3), 8'hFF, 1'b0);
    bus_read_chk(8'(BASE + 3), "R2 top bits zero");
    bus_write(8'(BASE - 1), 8'h3F, 1'b0);
    bus_write(8'(BASE + N), 8'h3F, 1'b0);
    bus_read_chk(8'(BASE - 1), "R2 below window");
    bus_read_chk(8'(BASE + N), "R2 above window");
    bus_read_chk(8'(BASE), "R2 first pin");
    bus_read_chk(8'(BASE + N - 1), "R2 last pin");
    bus_write(8'(BASE + N - 1), 8'h2A, 1'b0);
    bus_read_chk(8'(BASE + N - 1), "R2 last pin write");

    // R3 write protection
    bus_write(8'(BASE + 5), 8'h15, 1'b1);
    bus_read_chk(8'(BASE + 5), "R3 protected write");
    bus_read_chk(8'(BASE + 3), "R3 read while protected");
    pads_chk();

    // R6 open drain directed: pin 7 port-owned output, value 1 then 0
    bus_write(8'(BASE + 7), 8'h08, 1'b0);
    port_dir[7] = 1'b1; port_out[7] = 1'b1;
    #1; chk(pad_oe[7] == 1'b0, "R6 od high released", 64'(pad_oe[7]), 0);
    port_out[7] = 1'b0;
    #1; chk(pad_oe[7] == 1'b1, "R6 od low driven", 64'(pad_oe[7]), 1);

    // R9 slew codes on pins 0..3
    for (int c = 0; c < 4; c++) bus_write(8'(BASE + c), 8'(c << 4), 1'b0);
    #1; chk(pad_slew[7:0] == 8'b11_10_01_00, "R9 slew codes", 64'(pad_slew[7:0]), 64'hE4);

    // R8 latency and gating: pin 9 peripheral-owned with input on, pin 10 port output input off
    bus_write(8'(BASE + 9), 8'h03, 1'b0);
    bus_write(8'(BASE + 10), 8'h00, 1'b0);
    port_dir[10] = 1'b1;
    pad_in = '0;
    repeat (4) @(negedge clk);
    pad_in[9] = 1'b1; pad_in[10] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(in_value[9] == 1'b0, "R8 not before third edge", 64'(in_value[9]), 0);
    @(negedge clk);
    chk(in_value[9] == 1'b1, "R8 third edge capture", 64'(in_value[9]), 1);
    chk(in_value[10] == 1'b0, "R8 disabled reads zero", 64'(in_value[10]), 0);

    // Random mix
    void'($urandom(32'd2024));
    for (int it = 0; it < 400; it++) begin
      logic [7:0] a;
      a = ($urandom_range(0, 9) < 8) ? 8'(BASE + $urandom_range(0, N - 1))
                                    : 8'($urandom_range(0, 255));
      bus_write(a, 8'($urandom), ($urandom_range(0, 5) == 0));
      port_dir = $urandom; port_out = $urandom; alt_dir = $urandom; alt_out = $urandom;
      pad_in = $urandom; held = pad_in;
      pads_chk();
      repeat (3) @(negedge clk);
      chk(in_value == (held & fld_f(1)), "R8 random capture", 64'(in_value),
          64'(held & fld_f(1)));
      bus_read_chk(8'(BASE + $urandom_range(0, N - 1)), "R2/R3 random read");
      bus_read_chk(8'($urandom_range(0, 255)), "R2 random address");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule